// File: doc/BRIEF.md
# Watchdog Timer with Write-Once Overflow Action

This block supervises a small processor core. A free-running binary counter advances on every clock while the watchdog is running. Software must restart it by writing a clear code before it reaches the selected length. If the count completes, the block raises one of two single-cycle outputs: a request for a system reset, or an interrupt. The choice between them can be made only once after reset, and reset is the default. When the interrupt action is chosen, the counter wraps after each overflow and keeps counting, so the block then serves as a periodic interval timer.

Software reaches two byte-wide registers over a plain write bus. The control register sits at address 0x34 and the command register at address 0x35. The timeout length comes from a 2-bit period field, and each field value selects one of four power-of-two lengths. An input tells the block whether the core runs from the fast clock or the slow clock, and that input picks the set of lengths in use. Stopping the watchdog takes two steps. First the enable bit is cleared in the control register. Then a stop code is written to the command register.

The controller has three named states. RUN counts with the enable bit set. HOLD_OFF counts with the enable bit cleared, and a stop code is accepted only here. HALTED keeps the counter at zero. The transitions are:
- RUN to HOLD_OFF on a control write with enable 0.
- HOLD_OFF to RUN on a control write with enable 1.
- HOLD_OFF to HALTED on the stop code.
- HALTED to RUN on a control write with enable 1, which restarts the count from zero.

Top module: `wdog_top`

## Requirements
- R1: After reset the outputs are low, the watchdog runs with period field 0 and the reset action, and the action latch is unlocked.
- R2: The timeout is 2^(B+6-2*P) clock cycles, where P is the period field in control bits [3:2]. B is parameter FAST_BASE when slow_mode is 0 and SLOW_BASE when slow_mode is 1.
- R3: Writing 0x4E to the command register (0x35) in RUN or HOLD_OFF restarts the count, so the next overflow falls a full period after that write.
- R4: Values other than 0x4E and 0xB1 written to the command register have no effect on the count.
- R5: Control bit 1 chooses the action (0 selects reset request, 1 selects interrupt). Only the first control write after reset sets it, and later writes leave it unchanged until the next reset.
- R6: With the reset action, an overflow gives reset_req high for exactly one cycle, and irq stays low.
- R7: With the interrupt action, every overflow gives irq high for one cycle, and the counter wraps and keeps counting.
- R8: Writing 0xB1 to the command register in HOLD_OFF enters HALTED, where no overflow output occurs.
- R9: Writing 0xB1 while the enable bit (control bit 0) is 1 is ignored, and counting continues.
- R10: A control write with enable 1 in HALTED resumes counting from zero.
- R11: A control write that changes the period field, or a change of slow_mode, restarts the count from zero.
- R12: Clearing the enable bit alone does not stop counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_mode | input | 1 | 1 when the core runs from the slow clock |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write address (0x34 control, 0x35 command) |
| wr_data | input | 8 | Write data |
| reset_req | output | 1 | One-cycle system reset request |
| irq | output | 1 | One-cycle interrupt request |

## Verification
A write at clock edge k that restarts the count puts the counter at zero on that same edge. The overflow pulse then becomes visible just after edge k plus the period, and it drops one edge later. A change of slow_mode takes effect on the first edge that samples it. The bench counts every edge after a reference write and samples one time unit after each edge. It records the edge index of each pulse and compares that index with the period computed from the field value and the base exponent. Stimulus that should have no effect is checked by the overflow still landing exactly one period after the last valid restart.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    typedef enum logic [1:0] {
        ST_RUN      = 2'd0,
        ST_HOLD_OFF = 2'd1,
        ST_HALTED   = 2'd2
    } wd_state_t;

    localparam logic [7:0] ADDR_CTRL  = 8'h34;
    localparam logic [7:0] ADDR_CMD   = 8'h35;
    localparam logic [7:0] CODE_CLEAR = 8'h4E;
    localparam logic [7:0] CODE_STOP  = 8'hB1;

    localparam int BIT_EN  = 0;
    localparam int BIT_ACT = 1;
    localparam int SEL_LO  = 2;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_wr,
    input  logic [7:0] wr_data,
    input  logic       slow_mode,
    output logic [1:0] sel_q,
    output logic       slow_q,
    output logic       action_q,
    output logic       locked_q,
    output logic       tap_change
);
    logic [1:0] sel_new;

    assign sel_new    = wr_data[SEL_LO +: 2];
    assign tap_change = (ctrl_wr && (sel_new != sel_q)) || (slow_mode != slow_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q    <= 2'd0;
            slow_q   <= 1'b0;
            action_q <= 1'b0;
            locked_q <= 1'b0;
        end else begin
            slow_q <= slow_mode;
            if (ctrl_wr) begin
                sel_q <= sel_new;
                if (!locked_q) begin
                    action_q <= wr_data[BIT_ACT];
                    locked_q <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/wdog_fsm.sv
module wdog_fsm
    import wdog_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_wr,
    input  logic       en_bit,
    input  logic       cmd_wr,
    input  logic [7:0] cmd_data,
    output wd_state_t  state,
    output logic       cnt_en,
    output logic       clear_req
);
    wd_state_t state_d;
    logic      is_clear;
    logic      is_stop;

    assign is_clear = cmd_wr && (cmd_data == CODE_CLEAR);
    assign is_stop  = cmd_wr && (cmd_data == CODE_STOP);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_d;
    end

    always_comb begin
        state_d = state;
        unique case (state)
            ST_RUN:      if (ctrl_wr && !en_bit) state_d = ST_HOLD_OFF;
            ST_HOLD_OFF: begin
                if (ctrl_wr && en_bit) state_d = ST_RUN;
                else if (is_stop)      state_d = ST_HALTED;
            end
            ST_HALTED:   if (ctrl_wr && en_bit) state_d = ST_RUN;
            default:     state_d = ST_RUN;
        endcase
    end

    always_comb begin
        cnt_en    = 1'b0;
        clear_req = 1'b0;
        unique case (state)
            ST_RUN, ST_HOLD_OFF: begin
                cnt_en    = 1'b1;
                clear_req = is_clear;
            end
            ST_HALTED: begin
                cnt_en    = 1'b0;
                clear_req = 1'b1;
            end
            default: begin
                cnt_en    = 1'b0;
                clear_req = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int FAST_BASE = 17,
    parameter int SLOW_BASE = 9,
    localparam int CW = FAST_BASE + 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cnt_en,
    input  logic          cnt_clr,
    input  logic [1:0]    sel,
    input  logic          slow,
    input  logic          action,
    output logic [CW-1:0] cnt,
    output logic          reset_req,
    output logic          irq
);
    logic [CW-1:0] mask_tbl [8];
    logic [CW-1:0] mask;
    logic          ovf;

    for (genvar g = 0; g < 8; g++) begin : g_tap
        localparam int BASE = (g >= 4) ? SLOW_BASE : FAST_BASE;
        localparam int TAP  = BASE + 6 - 2 * (g % 4);
        assign mask_tbl[g] = CW'((64'd1 << TAP) - 64'd1);
    end

    assign mask = mask_tbl[{slow, sel}];
    assign ovf  = cnt_en && !cnt_clr && ((cnt & mask) == mask);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            reset_req <= 1'b0;
            irq       <= 1'b0;
        end else begin
            if (cnt_clr || ovf) cnt <= '0;
            else if (cnt_en)    cnt <= cnt + 1'b1;
            reset_req <= ovf && !action;
            irq       <= ovf && action;
        end
    end
endmodule

// File: rtl/wdog_top.sv
module wdog_top
    import wdog_pkg::*;
#(
    parameter int FAST_BASE = 17,
    parameter int SLOW_BASE = 9,
    localparam int CW = FAST_BASE + 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       slow_mode,
    input  logic       wr_en,
    input  logic [7:0] wr_addr,
    input  logic [7:0] wr_data,
    output logic       reset_req,
    output logic       irq
);
    logic          ctrl_wr;
    logic          cmd_wr;
    logic [1:0]    sel_q;
    logic          slow_q;
    logic          action_q;
    logic          locked_q;
    logic          tap_change;
    wd_state_t     state;
    logic          cnt_en;
    logic          clear_req;
    logic          cnt_clr;
    logic [CW-1:0] cnt;

    assign ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);
    assign cmd_wr  = wr_en && (wr_addr == ADDR_CMD);
    assign cnt_clr = clear_req || tap_change;

    wdog_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .wr_data    (wr_data),
        .slow_mode  (slow_mode),
        .sel_q      (sel_q),
        .slow_q     (slow_q),
        .action_q   (action_q),
        .locked_q   (locked_q),
        .tap_change (tap_change)
    );

    wdog_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (ctrl_wr),
        .en_bit    (wr_data[BIT_EN]),
        .cmd_wr    (cmd_wr),
        .cmd_data  (wr_data),
        .state     (state),
        .cnt_en    (cnt_en),
        .clear_req (clear_req)
    );

    wdog_counter #(
        .FAST_BASE (FAST_BASE),
        .SLOW_BASE (SLOW_BASE)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_en    (cnt_en),
        .cnt_clr   (cnt_clr),
        .sel       (sel_q),
        .slow      (slow_q),
        .action    (action_q),
        .cnt       (cnt),
        .reset_req (reset_req),
        .irq       (irq)
    );
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk
    import wdog_pkg::*;
#(
    parameter int CW = 23
) (
    input logic          clk,
    input logic          rst_n,
    input wd_state_t     state,
    input logic          locked,
    input logic          action,
    input logic          wr_en,
    input logic [7:0]    wr_addr,
    input logic [7:0]    wr_data,
    input logic [CW-1:0] cnt,
    input logic          reset_req,
    input logic          irq
);
    logic clear_wr;
    logic stop_wr;

    assign clear_wr = wr_en && (wr_addr == ADDR_CMD) && (wr_data == CODE_CLEAR);
    assign stop_wr  = wr_en && (wr_addr == ADDR_CMD) && (wr_data == CODE_STOP);

    a_r6_reset_single: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> !reset_req);

    a_r6_one_action: assert property (@(posedge clk) disable iff (!rst_n)
        !(reset_req && irq));

    a_r7_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    a_r5_action_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(action));

    a_r3_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_wr && state != ST_HALTED) |=> (cnt == '0));

    a_r8_halted_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALTED && $past(state) == ST_HALTED) |-> (!reset_req && !irq));

    a_r9_stop_needs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_wr && state == ST_RUN) |=> (state == ST_RUN));
endmodule

bind wdog_top wdog_chk #(.CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .locked    (locked_q),
    .action    (action_q),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .cnt       (cnt),
    .reset_req (reset_req),
    .irq       (irq)
);

// File: tb/wdog_top_tb_top.sv
module wdog_top_tb_top;
    localparam int FB = 5;
    localparam int SB = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slow_mode = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = 8'h00;
    logic [7:0] wr_data = 8'h00;
    logic       reset_req;
    logic       irq;

    int checks = 0;
    int errors = 0;
    int elapsed = 0;
    int rr_cnt = 0;
    int rr_at = -1;
    int irq_cnt = 0;
    int irq_first = -1;
    int irq_last = -1;
    bit done = 1'b0;

    always #4 clk = ~clk;

    wdog_top #(.FAST_BASE(FB), .SLOW_BASE(SB)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .slow_mode (slow_mode),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .reset_req (reset_req),
        .irq       (irq)
    );

    function automatic int period(input int slow, input int sel);
        return 1 << (((slow != 0) ? SB : FB) + 6 - 2 * sel);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic sample();
        elapsed++;
        if (reset_req) begin rr_cnt++; rr_at = elapsed; end
        if (irq) begin
            irq_cnt++;
            if (irq_first < 0) irq_first = elapsed;
            irq_last = elapsed;
        end
    endtask

    task automatic zero();
        elapsed = 0; rr_cnt = 0; rr_at = -1;
        irq_cnt = 0; irq_first = -1; irq_last = -1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
        sample();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            sample();
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++;
            $display("FAIL watchdog run did not finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        #1;
        check("R1 reset_req after reset", int'(reset_req), 0);
        check("R1 irq after reset", int'(irq), 0);

        // R1/R2/R6: default period field 0, fast clock, reset action
        wr(8'h35, 8'h4E); zero();
        idle(period(0, 0) + 40);
        check("R1 R2 default timeout", rr_at, period(0, 0));
        check("R6 reset_req one cycle", rr_cnt, 1);
        check("R6 irq stays low", irq_cnt, 0);

        // R3: clear restarts the timeout
        wr(8'h35, 8'h4E); zero();
        idle(1500);
        wr(8'h35, 8'h4E); elapsed = 0;
        idle(period(0, 0) + 10);
        check("R3 restart timing", rr_at, period(0, 0));
        check("R3 single pulse over both windows", rr_cnt, 1);

        // R4/R9: invalid codes and stop while enabled change nothing
        wr(8'h35, 8'h4E); zero();
        idle(500);
        wr(8'h35, 8'h00);
        wr(8'h35, 8'h4F);
        wr(8'h35, 8'hB1);
        idle(1600);
        check("R4 R9 timeout unaffected", rr_at, period(0, 0));

        // R5/R7/R11: first control write picks interrupt, period 3
        wr(8'h34, 8'h0F); zero();
        idle(100);
        check("R7 irq count", irq_cnt, 3);
        check("R7 last irq wraps", irq_last, 3 * period(0, 3));
        check("R7 no reset_req", rr_cnt, 0);

        // R5: a second control write cannot change the action
        wr(8'h34, 8'h0D);
        wr(8'h35, 8'h4E); zero();
        idle(70);
        check("R5 action locked irq", irq_cnt, 2);
        check("R5 action locked no reset", rr_cnt, 0);

        // R11: period change clears a stale count
        wr(8'h35, 8'h4E);
        idle(20);
        wr(8'h34, 8'h0B); zero();
        idle(period(0, 2) + 5);
        check("R11 period change restart", irq_first, period(0, 2));

        // R11: slow_mode change clears the count (clearing edge is elapsed 1)
        wr(8'h34, 8'h0F);
        idle(20);
        slow_mode = 1'b1; zero();
        idle(period(1, 3) + 3);
        check("R11 mode change restart", irq_first, period(1, 3) + 1);

        // R2: sweep both clock modes and all period fields
        for (int s = 0; s < 2; s++) begin
            for (int p = 0; p < 4; p++) begin
                slow_mode = (s != 0);
                wr(8'h34, 8'((p << 2) | 3));
                wr(8'h35, 8'h4E); zero();
                idle(period(s, p) + 3);
                check($sformatf("R2 period slow=%0d sel=%0d", s, p), irq_first, period(s, p));
                check($sformatf("R2 pulse count slow=%0d sel=%0d", s, p), irq_cnt, 1);
            end
        end

        // R12/R8/R10: fast mode, period 3, interrupt action
        slow_mode = 1'b0;
        wr(8'h34, 8'h0F);
        wr(8'h35, 8'h4E); zero();
        wr(8'h34, 8'h0E);
        idle(39);
        check("R12 counting continues after enable cleared", irq_first, period(0, 3));
        wr(8'h35, 8'hB1); zero();
        idle(200);
        check("R8 halted no irq", irq_cnt, 0);
        check("R8 halted no reset_req", rr_cnt, 0);
        wr(8'h34, 8'h0F); zero();
        idle(40);
        check("R10 resume from zero", irq_first, period(0, 3));

        // R1/R5: a new reset unlocks the action latch
        do_reset();
        #1;
        check("R1 outputs low after second reset", int'(reset_req | irq), 0);
        wr(8'h34, 8'h0F); zero();
        idle(40);
        check("R5 latch free after reset", irq_first, period(0, 3));

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule